// File: doc/BRIEF.md
# Register Auto-Modify Tracking Register

This block keeps a running record of the general-register increments and decrements that occur while one instruction runs. After a memory-management abort, recovery software reads this record and undoes each adjustment, so the faulting instruction can be restarted cleanly. The address-mode logic sends one event for each register adjustment. Each event carries a 3-bit register number and a signed 5-bit amount. The block packs up to two distinct registers into one 16-bit word.

A pulse at the start of each instruction empties the record. Events that follow fill the low byte first, then the high byte. Further events for a register that already holds a byte add into that byte's amount. Address calculations in index mode are not recorded. While any of the three abort flags in the status register is set, the record is frozen, which lets it be inspected. When all three flags are clear again, tracking resumes at the next instruction start. Both the asynchronous reset and the synchronous bus reset empty the record.

Top module: `regmod_tracker`

## Requirements
- R1: Asynchronous reset and a `bus_clr` pulse each leave `trk_value` equal to 0x0000. `bus_clr` acts even while the record is frozen, and the value reads zero in the cycle after the pulse.
- R2: The first register recorded after an instruction start appears in the low byte. Bits 2..0 hold the register number and bits 7..3 hold the amount in two's complement, so +2 is 00010 and −2 is 11110. The value is visible in the cycle after the event.
- R3: A second, different register appears in the high byte in the same layout: bits 10..8 hold the register number and bits 15..11 hold the amount.
- R4: While the record is not frozen, `instr_start` empties it. An instruction that adjusts no register therefore reads 0x0000. An event in the same cycle as `instr_start` is the first entry of the new instruction.
- R5: When only one register is adjusted, bits 15..8 stay zero.
- R6: Further events for a register already held add into its amount, modulo 32, without taking a new byte. The register number stays in place even when the sum is zero.
- R7: An event marked as an index-mode calculation (`mod_index` = 1) leaves `trk_value` unchanged.
- R8: While any bit of `abort_flags` is 1, `trk_value` holds its value through events and instruction starts. The only exception is `bus_clr`.
- R9: Once all abort flags are 0, the next `instr_start` empties the record and recording resumes.
- R10: Register number 7 is recorded in exactly the same way as any other register.
- R11: An event for a third distinct register, once both bytes are taken, leaves `trk_value` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clr | input | 1 | Synchronous bus reset; empties the record |
| instr_start | input | 1 | Pulse at the start of each instruction |
| mod_valid | input | 1 | A register adjustment event is present |
| mod_index | input | 1 | The event is an index-mode calculation and is to be ignored |
| mod_reg | input | 3 | Register number of the event |
| mod_delta | input | 5 | Signed amount of the event, two's complement |
| abort_flags | input | 3 | Abort flags of the status register; any set bit freezes the record |
| trk_value | output | 16 | Packed record: high byte = second register, low byte = first register |

## Verification
Each piece of internal state shows at the port one cycle after the event that touches it. A wrong byte-occupied flag makes a repeated register take the high byte instead of summing, or lets a third register overwrite an entry. Either fault changes `trk_value` on the very next read. A freeze decision that leaks shows up as a changed word on the cycle after an event or start arrives under a set abort flag. A lost clear shows up as stale bytes one cycle after `instr_start` or `bus_clr`.

// File: rtl/trk_pkg.sv
package trk_pkg;
  // default geometry of the tracking record
  localparam int TRK_REG_W   = 3;
  localparam int TRK_DELTA_W = 5;
  localparam int TRK_SLOTS   = 2;
endpackage

// File: rtl/trk_event_gate.sv
module trk_event_gate #(
  parameter int FLAG_W = 3
) (
  input  logic              bus_clr,
  input  logic              instr_start,
  input  logic              mod_valid,
  input  logic              mod_index,
  input  logic [FLAG_W-1:0] abort_flags,
  output logic              frozen_o,
  output logic              clr_o,
  output logic              take_o
);
  always_comb begin
    frozen_o = |abort_flags;
    clr_o    = bus_clr | (instr_start & ~frozen_o);
    take_o   = mod_valid & ~mod_index & ~frozen_o & ~bus_clr;
  end
endmodule

// File: rtl/trk_slot.sv
module trk_slot #(
  parameter int REG_W   = 3,
  parameter int DELTA_W = 5,
  localparam int FIELD_W = REG_W + DELTA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               take_new_i,
  input  logic               take_add_i,
  input  logic [REG_W-1:0]   ev_reg_i,
  input  logic [DELTA_W-1:0] ev_delta_i,
  output logic               used_o,
  output logic [REG_W-1:0]   reg_o,
  output logic [FIELD_W-1:0] field_o
);
  logic               used_q, used_d;
  logic [REG_W-1:0]   reg_q, reg_d;
  logic [DELTA_W-1:0] delta_q, delta_d;
  logic               en;

  always_comb begin
    en      = take_new_i | take_add_i | clr_i;
    used_d  = used_q;
    reg_d   = reg_q;
    delta_d = delta_q;
    if (take_new_i) begin
      used_d  = 1'b1;
      reg_d   = ev_reg_i;
      delta_d = ev_delta_i;
    end else if (take_add_i) begin
      delta_d = delta_q + ev_delta_i;
    end else if (clr_i) begin
      used_d  = 1'b0;
      reg_d   = '0;
      delta_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= 1'b0;
      reg_q   <= '0;
      delta_q <= '0;
    end else if (en) begin
      used_q  <= used_d;
      reg_q   <= reg_d;
      delta_q <= delta_d;
    end
  end

  assign used_o  = used_q;
  assign reg_o   = reg_q;
  assign field_o = {delta_q, reg_q};

  // R6
  add_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_add_i |-> used_q);
endmodule

// File: rtl/regmod_tracker.sv
module regmod_tracker
  import trk_pkg::*;
#(
  parameter int REG_W   = TRK_REG_W,
  parameter int DELTA_W = TRK_DELTA_W,
  parameter int SLOTS   = TRK_SLOTS,
  parameter int FLAG_W  = 3,
  localparam int FIELD_W = REG_W + DELTA_W,
  localparam int OUT_W   = SLOTS * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_clr,
  input  logic               instr_start,
  input  logic               mod_valid,
  input  logic               mod_index,
  input  logic [REG_W-1:0]   mod_reg,
  input  logic [DELTA_W-1:0] mod_delta,
  input  logic [FLAG_W-1:0]  abort_flags,
  output logic [OUT_W-1:0]   trk_value
);
  logic             frozen, clr_now, take;
  logic [SLOTS-1:0] used, eff_used, hit, take_new, take_add;
  logic [SLOTS:0]   claim;

  trk_event_gate #(.FLAG_W(FLAG_W)) u_gate (
    .bus_clr     (bus_clr),
    .instr_start (instr_start),
    .mod_valid   (mod_valid),
    .mod_index   (mod_index),
    .abort_flags (abort_flags),
    .frozen_o    (frozen),
    .clr_o       (clr_now),
    .take_o      (take)
  );

  assign claim[0] = 1'b0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [REG_W-1:0] reg_i;

    always_comb begin
      eff_used[i] = used[i] & ~clr_now;
      hit[i]      = eff_used[i] && (reg_i == mod_reg);
      take_new[i] = take & ~eff_used[i] & ~claim[i];
      take_add[i] = take & hit[i] & ~claim[i];
    end
    assign claim[i+1] = claim[i] | take_new[i] | take_add[i];

    trk_slot #(.REG_W(REG_W), .DELTA_W(DELTA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_now),
      .take_new_i (take_new[i]),
      .take_add_i (take_add[i]),
      .ev_reg_i   (mod_reg),
      .ev_delta_i (mod_delta),
      .used_o     (used[i]),
      .reg_o      (reg_i),
      .field_o    (trk_value[i*FIELD_W +: FIELD_W])
    );

    if (i > 0) begin : g_order
      // R3
      fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used[i] |-> used[i-1]);
    end
  end

  // R1
  bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clr |=> (trk_value == '0));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|abort_flags) && !bus_clr) |=> $stable(trk_value));

  // R4
  idle_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && !mod_valid && !(|abort_flags)) |=> (trk_value == '0));

  // R7
  index_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_valid && mod_index && !instr_start && !bus_clr) |=> $stable(trk_value));

  // R2
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_new | take_add));
endmodule

// File: tb/sim_regmod_tracker.sv
module sim_regmod_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_clr = 1'b0;
  logic        instr_start = 1'b0;
  logic        mod_valid = 1'b0;
  logic        mod_index = 1'b0;
  logic [2:0]  mod_reg = '0;
  logic [4:0]  mod_delta = '0;
  logic [2:0]  abort_flags = '0;
  logic [15:0] trk_value;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  regmod_tracker u0 (
    .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .instr_start(instr_start),
    .mod_valid(mod_valid), .mod_index(mod_index), .mod_reg(mod_reg),
    .mod_delta(mod_delta), .abort_flags(abort_flags), .trk_value(trk_value)
  );

  task automatic chk(input string tag, input logic [15:0] exp);
    checks++;
    if (trk_value !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, trk_value, exp);
    end
  endtask

  // one clock with the given inputs; sampled 1 ns after the edge
  task automatic cyc(input logic st, input logic v, input logic ix,
                     input logic [2:0] r, input logic [4:0] d);
    instr_start = st; mod_valid = v; mod_index = ix; mod_reg = r; mod_delta = d;
    @(posedge clk); #1;
    instr_start = 1'b0; mod_valid = 1'b0; mod_index = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 async reset", 16'h0000);
  endtask

  task automatic t_single;
    cyc(1, 1, 0, 3'd1, 5'd2);
    chk("R2 r1 +2 low byte", 16'h0011);
    chk("R5 high byte zero", 16'h0011);
    cyc(1, 1, 0, 3'd1, 5'b11110);
    chk("R2 r1 -2 low byte", 16'h00F1);
  endtask

  task automatic t_pair;
    cyc(1, 1, 0, 3'd1, 5'd2);
    cyc(0, 1, 0, 3'd2, 5'd2);
    chk("R3 r1+2 r2+2", 16'h1211);
    cyc(1, 1, 0, 3'd1, 5'b11110);
    cyc(0, 1, 0, 3'd2, 5'b11110);
    chk("R3 r1-2 r2-2", 16'hF2F1);
    cyc(1, 0, 0, 3'd0, 5'd0);
    chk("R4 idle instruction", 16'h0000);
  endtask

  task automatic t_accum;
    cyc(1, 1, 0, 3'd3, 5'd2);
    cyc(0, 1, 0, 3'd3, 5'd2);
    chk("R6 r3 +2 +2", 16'h0023);
    cyc(0, 1, 0, 3'd3, 5'b11100);
    chk("R6 r3 sums to zero", 16'h0003);
    cyc(1, 1, 0, 3'd5, 5'd16);
    cyc(0, 1, 0, 3'd5, 5'd16);
    chk("R6 wrap modulo 32", 16'h0005);
    cyc(1, 1, 0, 3'd1, 5'd2);
    cyc(0, 1, 0, 3'd2, 5'd1);
    cyc(0, 1, 0, 3'd2, 5'd1);
    chk("R6 second byte sums", 16'h1211);
  endtask

  task automatic t_index;
    cyc(1, 1, 0, 3'd1, 5'b11110);
    cyc(0, 1, 1, 3'd3, 5'd2);
    chk("R7 index event ignored", 16'h00F1);
    cyc(1, 1, 1, 3'd4, 5'd2);
    chk("R7 index at start ignored", 16'h0000);
  endtask

  task automatic t_pc_third;
    cyc(1, 1, 0, 3'd7, 5'd2);
    chk("R10 pc recorded", 16'h0017);
    cyc(1, 1, 0, 3'd1, 5'd2);
    cyc(0, 1, 0, 3'd2, 5'd2);
    cyc(0, 1, 0, 3'd4, 5'd2);
    chk("R11 third register ignored", 16'h1211);
  endtask

  task automatic t_freeze;
    for (int b = 0; b < 3; b++) begin
      abort_flags = '0;
      cyc(1, 1, 0, 3'd1, 5'd2);
      cyc(0, 1, 0, 3'd2, 5'd2);
      abort_flags = 3'(1 << b);
      cyc(1, 1, 0, 3'd4, 5'd2);
      chk($sformatf("R8 flag %0d start held", b), 16'h1211);
      cyc(0, 1, 0, 3'd1, 5'd2);
      chk($sformatf("R8 flag %0d event held", b), 16'h1211);
    end
    bus_clr = 1'b1;
    cyc(0, 0, 0, 3'd0, 5'd0);
    bus_clr = 1'b0;
    chk("R1 bus clear while frozen", 16'h0000);
    cyc(0, 1, 0, 3'd6, 5'd2);
    chk("R8 frozen after bus clear", 16'h0000);
    abort_flags = '0;
    cyc(1, 1, 0, 3'd6, 5'b11110);
    chk("R9 resume after flags clear", 16'h00F6);
  endtask

  initial begin
    #10 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_accum();
    t_index();
    t_pc_third();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule